// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a single-rank SDR SDRAM with four internal banks, 13 row-address bits and 9 column-address bits. After reset it raises clock enable and waits out the power-up interval. It then closes every bank and issues a burst of back-to-back auto-refresh commands. Next it programs the mode register, and from then on it keeps the array refreshed on a fixed period. Every gap between two commands is a separate cycle-count parameter.

A separate read/write engine shares the command pins and takes them by holding `grant_i`. When the refresh period elapses, the sequencer raises `refresh_req_o`. The refresh starts only after the engine drops its grant. While the refresh runs, `refresh_busy_o` is high, and the engine must keep off the pins until it falls. `init_done_o` tells the engine that the device can be used.

Top module: `sdram_pwrup_refresh`

## Requirements
- R1: While `rst_n` is low, and until clock enable rises, `cke_o` is 0, the pins carry NOP, and `init_done_o`, `refresh_busy_o` and `refresh_req_o` are 0. Bank and address outputs are 0 whenever no command needs them.
- R2: Reset is released through a two-stage synchronizer. `cke_o` rises on the third rising edge after `rst_n` goes high. The pins then carry NOP for `PWRUP_CYC` cycles, followed by a PRECHARGE with address bit 10 set to 1 (all banks) and every other address bit 0.
- R3: Commands are encoded on {`cs_n_o`,`ras_n_o`,`cas_n_o`,`we_n_o`} as NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001 and LOAD MODE=0000. Every cycle that carries no command carries NOP.
- R4: `T_RP` cycles after the power-up PRECHARGE, `INIT_REFRESHES` (default 8) AUTO REFRESH commands follow, each `T_RC` cycles after the previous one.
- R5: LOAD MODE comes `T_RC` cycles after the last power-up refresh. It carries address 0x230 (burst length 1, sequential, CAS latency 3, standard mode, single-location writes) and bank 0.
- R6: `init_done_o` rises `T_MRD` cycles after LOAD MODE and stays high until the next reset.
- R7: `refresh_req_o` first rises `REFRESH_RELOAD` cycles after `init_done_o` rises. The period timer then expires every `REFRESH_RELOAD` cycles. An expiry while a request is already pending leaves a single request pending.
- R8: A pending request is taken on an edge where the sequencer is idle and `grant_i` is low. On that edge `refresh_busy_o` rises and `refresh_req_o` falls. PRECHARGE-all follows max(`T_WR`,`T_RAS`) cycles later, AUTO REFRESH follows `T_RP` cycles after that, and `refresh_busy_o` falls `T_RC` cycles after the AUTO REFRESH.
- R9: While `grant_i` is high and no refresh is running, the sequencer issues no command, and a pending `refresh_req_o` stays high.
- R10: `grant_i` has no effect once a refresh has started: the command timing of R8 is unchanged.
- R11: Pulling `rst_n` low drops `init_done_o`, `refresh_busy_o`, `refresh_req_o` and `cke_o` at once, without waiting for a clock edge. The power-up order of R2 then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same as the SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Read/write engine holds the command pins |
| init_done_o | output | 1 | Device initialised and usable |
| refresh_req_o | output | 1 | A periodic refresh is pending |
| refresh_busy_o | output | 1 | Refresh sequence in progress |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank select |
| addr_o | output | ROW_W | Address bus |

## Verification
Most faults in the state or the delay counter show up at the pins within one command gap. A wrong state moves a command by a cycle or replaces it with another encoding, and the bench compares the pins with its model every cycle. A fault in the period timer or the pending flag stays hidden longer: it appears only when `refresh_req_o` rises, which is up to one reload interval later. For that reason the bench runs several periods with the grant held low, held high and toggling. A wrong count of power-up refreshes shows up as a LOAD MODE out of place at the end of the initialisation.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_OFF, ST_PWRUP, ST_IPRE, ST_IRP, ST_IREF, ST_IRC, ST_LMR, ST_MRD,
    ST_IDLE, ST_GUARD, ST_PRE, ST_RP, ST_REF, ST_RC
  } seq_st_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // burst length 1, sequential, standard mode
  function automatic logic [12:0] mode_word(input int cas, input logic wr_single);
    return {3'b000, wr_single, 2'b00, 3'(cas), 1'b0, 3'b000};
  endfunction

endpackage

// File: rtl/sdseq_rst_sync.sv
module sdseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/sdseq_delay.sv
module sdseq_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdseq_refresh_timer.sv
module sdseq_refresh_timer #(
  parameter int RELOAD = 1855
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int TW = (RELOAD > 2) ? $clog2(RELOAD) : 1;
  localparam logic [TW-1:0] RELOAD_M1 = TW'(RELOAD - 1);

  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    expire = run && (tmr_q == '0);
    tmr_d  = (tmr_q == '0) ? RELOAD_M1 : (tmr_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tmr_q <= RELOAD_M1;
    else if (run) tmr_q <= tmr_d;
  end
endmodule

// File: rtl/sdseq_pin_encoder.sv
module sdseq_pin_encoder
  import sdseq_pkg::*;
#(
  parameter int              ROW_W     = 13,
  parameter int              BANK_W    = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_e           state_d,
  output logic              cke_o,
  output sd_cmd_e           cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              done_o,
  output logic              busy_o
);
  sd_cmd_e          cmd_d;
  logic [ROW_W-1:0] addr_d;
  logic             busy_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    addr_d = '0;
    unique case (state_d)
      ST_IPRE, ST_PRE: begin
        cmd_d      = CMD_PRE;
        addr_d[10] = 1'b1;
      end
      ST_IREF, ST_REF: cmd_d = CMD_AREF;
      ST_LMR: begin
        cmd_d  = CMD_LMR;
        addr_d = MODE_WORD;
      end
      default: ;
    endcase
    busy_d = (state_d == ST_GUARD) || (state_d == ST_PRE) || (state_d == ST_RP) ||
             (state_d == ST_REF)   || (state_d == ST_RC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_o  <= 1'b0;
      cmd_o  <= CMD_NOP;
      ba_o   <= '0;
      addr_o <= '0;
      done_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      cke_o  <= (state_d != ST_OFF);
      cmd_o  <= cmd_d;
      ba_o   <= '0;
      addr_o <= addr_d;
      done_o <= done_o || (state_d == ST_IDLE);
      busy_o <= busy_d;
    end
  end
endmodule

// File: rtl/sdram_pwrup_refresh.sv
module sdram_pwrup_refresh
  import sdseq_pkg::*;
#(
  parameter int ROW_W          = 13,
  parameter int BANK_W         = 2,
  parameter int PWRUP_CYC      = 12000,
  parameter int REFRESH_RELOAD = 1855,
  parameter int INIT_REFRESHES = 8,
  parameter int CAS_LAT        = 3,
  parameter int T_MRD          = 2,
  parameter int T_RAS          = 5,
  parameter int T_RC           = 8,
  parameter int T_WR           = 2,
  parameter int T_RP           = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_i,
  output logic              init_done_o,
  output logic              refresh_req_o,
  output logic              refresh_busy_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o
);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(mode_word(CAS_LAT, 1'b1));
  localparam int GUARD_CYC = max_of(T_WR, T_RAS);
  localparam int MAX_DLY   = max_of(max_of(PWRUP_CYC, GUARD_CYC),
                                    max_of(max_of(T_RC, T_RP), T_MRD));
  localparam int CNT_W     = $clog2(MAX_DLY + 1);
  localparam int REF_W     = $clog2(INIT_REFRESHES + 1);

  logic             rst_n_s;
  seq_st_e          state_q, state_d;
  logic             dly_load, dly_zero;
  logic [CNT_W-1:0] dly_val;
  logic [REF_W-1:0] ref_left_q, ref_left_d;
  logic             pend_q, pend_d, tmr_expire, svc;
  sd_cmd_e          cmd;

  sdseq_rst_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  sdseq_delay #(.CNT_W(CNT_W)) u_dly (
    .clk(clk), .rst_n(rst_n_s), .load(dly_load), .load_val(dly_val), .expired(dly_zero)
  );

  sdseq_refresh_timer #(.RELOAD(REFRESH_RELOAD)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .run(init_done_o), .expire(tmr_expire)
  );

  sdseq_pin_encoder #(.ROW_W(ROW_W), .BANK_W(BANK_W), .MODE_WORD(MODE_WORD)) u_enc (
    .clk(clk), .rst_n(rst_n_s), .state_d(state_d), .cke_o(cke_o), .cmd_o(cmd),
    .ba_o(ba_o), .addr_o(addr_o), .done_o(init_done_o), .busy_o(refresh_busy_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign refresh_req_o = pend_q;
  assign svc = (state_q == ST_IDLE) && pend_q && !grant_i;

  // next state
  always_comb begin
    state_d    = state_q;
    dly_load   = 1'b0;
    dly_val    = '0;
    ref_left_d = ref_left_q;
    unique case (state_q)
      ST_OFF: begin
        state_d  = ST_PWRUP;
        dly_load = 1'b1;
        dly_val  = CNT_W'(PWRUP_CYC - 1);
      end
      ST_PWRUP: if (dly_zero) state_d = ST_IPRE;
      ST_IPRE: begin
        state_d    = ST_IRP;
        dly_load   = 1'b1;
        dly_val    = CNT_W'(T_RP - 2);
        ref_left_d = REF_W'(INIT_REFRESHES - 1);
      end
      ST_IRP: if (dly_zero) state_d = ST_IREF;
      ST_IREF: begin
        state_d  = ST_IRC;
        dly_load = 1'b1;
        dly_val  = CNT_W'(T_RC - 2);
      end
      ST_IRC: if (dly_zero) begin
        if (ref_left_q == '0) state_d = ST_LMR;
        else begin
          state_d    = ST_IREF;
          ref_left_d = ref_left_q - 1'b1;
        end
      end
      ST_LMR: begin
        state_d  = ST_MRD;
        dly_load = 1'b1;
        dly_val  = CNT_W'(T_MRD - 2);
      end
      ST_MRD: if (dly_zero) state_d = ST_IDLE;
      ST_IDLE: if (svc) begin
        state_d  = ST_GUARD;
        dly_load = 1'b1;
        dly_val  = CNT_W'(GUARD_CYC - 1);
      end
      ST_GUARD: if (dly_zero) state_d = ST_PRE;
      ST_PRE: begin
        state_d  = ST_RP;
        dly_load = 1'b1;
        dly_val  = CNT_W'(T_RP - 2);
      end
      ST_RP: if (dly_zero) state_d = ST_REF;
      ST_REF: begin
        state_d  = ST_RC;
        dly_load = 1'b1;
        dly_val  = CNT_W'(T_RC - 2);
      end
      ST_RC: if (dly_zero) state_d = ST_IDLE;
      default: state_d = ST_OFF;
    endcase
    pend_d = tmr_expire ? 1'b1 : (svc ? 1'b0 : pend_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_OFF;
      ref_left_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      ref_left_q <= ref_left_d;
      pend_q     <= pend_d;
    end
  end
endmodule

// File: rtl/sdseq_checker.sv
module sdseq_checker #(
  parameter int               ROW_W     = 13,
  parameter int               BANK_W    = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant_i,
  input logic              init_done_o,
  input logic              refresh_req_o,
  input logic              refresh_busy_o,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BANK_W-1:0] ba_o,
  input logic [ROW_W-1:0]  addr_o
);
  logic [3:0] pins;
  assign pins = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  assert_legal_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0111) || (pins == 4'b0010) || (pins == 4'b0001) || (pins == 4'b0000));

  assert_quiet_before_cke_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> (pins == 4'b0111) && !init_done_o && !refresh_busy_o);

  assert_pre_all_banks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0010) |-> addr_o[10]);

  assert_mode_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> (addr_o == MODE_WORD) && (ba_o == '0));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);

  assert_req_after_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req_o |-> init_done_o);

  assert_start_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_busy_o && !$past(refresh_busy_o)) |-> ($past(refresh_req_o) && !$past(grant_i)));

  assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done_o && !refresh_busy_o && grant_i) |=> ((pins == 4'b0111) && !refresh_busy_o));
endmodule

bind sdram_pwrup_refresh sdseq_checker #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .MODE_WORD(MODE_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .init_done_o(init_done_o),
  .refresh_req_o(refresh_req_o), .refresh_busy_o(refresh_busy_o), .cke_o(cke_o),
  .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
  .ba_o(ba_o), .addr_o(addr_o)
);

// File: tb/sim_sdram_pwrup_refresh.sv
module sim_sdram_pwrup_refresh;
  localparam int PW    = 40;
  localparam int RL    = 80;
  localparam int NREF  = 8;
  localparam int TRP   = 2;
  localparam int TRC   = 8;
  localparam int TMRD  = 2;
  localparam int GUARD = 5;   // max(write recovery 2, active-to-precharge 5)
  localparam logic [3:0]  C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;
  localparam logic [12:0] A_PRE = 13'h0400, A_MODE = 13'h0230;

  logic clk = 1'b0;
  logic rst_n, grant;
  logic done, req, busy, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #2.5ns clk = ~clk;

  sdram_pwrup_refresh #(.PWRUP_CYC(PW), .REFRESH_RELOAD(RL), .INIT_REFRESHES(NREF),
    .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD)) u0 (
    .clk(clk), .rst_n(rst_n), .grant_i(grant), .init_done_o(done), .refresh_req_o(req),
    .refresh_busy_o(busy), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .ba_o(ba), .addr_o(addr));

  int vectors = 0, errors = 0;
  logic        e_cke = 0, e_done = 0, e_busy = 0, e_req = 0;
  logic [3:0]  e_cmd = C_NOP;
  logic [12:0] e_addr = '0;
  string       cur = "R1";
  bit          cmp_en = 0, go = 0, stop = 0, tmr_on = 0, m_pend = 0;
  int          tmr = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (cmp_en) begin
    logic [22:0] a, e;
    a = {cke, cs_n, ras_n, cas_n, we_n, ba, addr, done, busy, req};
    e = {e_cke, e_cmd, 2'b00, e_addr, e_done, e_busy, e_req};
    check(a === e, cur, "pins{cke,cmd,ba,addr,done,busy,req}", 32'(a), 32'(e));
  end

  // one clock of the model
  task automatic tick(input logic [3:0] c, input logic [12:0] a, input bit ck, input bit dn,
                      input bit bz, input bit try_svc, input string rq, output bit svc);
    bit fire;
    @(posedge clk);
    svc  = try_svc && m_pend && !grant;
    fire = tmr_on && (tmr == 0);
    if (tmr_on) tmr = fire ? RL - 1 : tmr - 1;
    if (fire) m_pend = 1;
    else if (svc) m_pend = 0;
    e_cmd = c; e_addr = a; e_cke = ck; e_done = dn; e_busy = bz || svc; e_req = m_pend;
    cur = svc ? "R8" : rq;
  endtask

  task automatic rtick(input logic [3:0] c, input logic [12:0] a);
    bit s;
    tick(c, a, 1, 1, 1, 0, grant ? "R10" : "R8", s);
  endtask

  initial begin : model
    bit s;
    wait (go);
    for (int i = 0; i < 2; i++) tick(C_NOP, '0, 0, 0, 0, 0, "R1", s);
    for (int i = 0; i < PW; i++) tick(C_NOP, '0, 1, 0, 0, 0, "R2", s);
    tick(C_PRE, A_PRE, 1, 0, 0, 0, "R2,R3", s);
    for (int i = 0; i < TRP - 1; i++) tick(C_NOP, '0, 1, 0, 0, 0, "R4", s);
    for (int n = 0; n < NREF; n++) begin
      tick(C_REF, '0, 1, 0, 0, 0, "R3,R4", s);
      for (int i = 0; i < TRC - 1; i++) tick(C_NOP, '0, 1, 0, 0, 0, "R4", s);
    end
    tick(C_LMR, A_MODE, 1, 0, 0, 0, "R5", s);
    for (int i = 0; i < TMRD - 1; i++) tick(C_NOP, '0, 1, 0, 0, 0, "R6", s);
    tick(C_NOP, '0, 1, 1, 0, 0, "R6", s);
    tmr = RL - 1;
    tmr_on = 1;
    while (!stop) begin
      tick(C_NOP, '0, 1, 1, 0, 1, grant ? "R9" : "R7", s);
      if (s) begin
        for (int i = 0; i < GUARD - 1; i++) rtick(C_NOP, '0);
        rtick(C_PRE, A_PRE);
        for (int i = 0; i < TRP - 1; i++) rtick(C_NOP, '0);
        rtick(C_REF, '0);
        for (int i = 0; i < TRC - 1; i++) rtick(C_NOP, '0);
        tick(C_NOP, '0, 1, 1, 0, 0, "R8", s);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0;
    grant = 1'b0;
    cmp_en = 1;                       // R1: reset state compared each cycle
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    go = 1;
    repeat (140) @(negedge clk);      // power-up sequence
    repeat (200) @(negedge clk);      // grant low: prompt refreshes (R7, R8)
    grant = 1'b1;                     // hold-off across two expiries (R9)
    repeat (250) @(negedge clk);
    grant = 1'b0;
    repeat (100) @(negedge clk);
    for (int i = 0; i < 400; i++) begin   // toggling grant, also during busy (R10)
      @(negedge clk);
      grant = ((i % 11) < 4);
    end
    grant = 1'b0;
    repeat (60) @(negedge clk);
    stop = 1;
    cmp_en = 0;
    // R11: asynchronous return to reset values
    #1ns rst_n = 1'b0;
    #1ns;
    check({done, busy, req, cke} == 4'b0000, "R11", "done,busy,req,cke", 32'({done, busy, req, cke}), 0);
    check({cs_n, ras_n, cas_n, we_n} == C_NOP, "R11", "cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'(C_NOP));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cke == 1'b0, "R2", "cke after edge 1", 32'(cke), 0);
    @(negedge clk);
    check(cke == 1'b0, "R2", "cke after edge 2", 32'(cke), 0);
    @(negedge clk);
    check(cke == 1'b1, "R2", "cke after edge 3", 32'(cke), 1);
    check(done == 1'b0, "R11", "init_done after restart", 32'(done), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule